// File: doc/BRIEF.md
# Five-Lane Junction Signal Sequencer

This block drives the lamp pole at the centre of a five-lane junction. Three of the lanes (0, 2 and 3) are trunk roads. The other two (1 and 4) are minor roads, and each has a presence detector. The block drives a red, a green and a yellow lamp for every lane, and it gives the right of way to exactly one lane at a time. That lane gets a green interval and then a yellow interval. When the yellow interval ends, the lane goes red and the next lane turns green.

The lanes are served by stepping the lane index upward and wrapping from 4 back to 0. After reset the sequence starts at lane 2, so the order is 2, 3, 4, 0, 1, and then it repeats. A minor lane is served only when its detector reports a waiting vehicle at the moment the preceding lane's yellow interval ends. Otherwise both its green and its yellow are skipped, and the lane after it is served instead.

A prescaler divides the clock into a one-cycle pulse once per second. All interval lengths are counted in those pulses, and they are parameters of the block.

Top module: `lane_signal_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the prescaler and puts lane 2 in green with a full trunk green interval. Lane 2 therefore shows green for exactly HWY_GREEN_S x TICKS_PER_SEC cycles after reset is released.
- R2: In every cycle out of reset, exactly one lane shows green or yellow, and no lane shows green and yellow together.
- R3: Bit i of lamp_red, lamp_grn and lamp_yel belongs to lane i, and 1 means lit. A lane that is neither green nor yellow shows red. A lane that is green or yellow shows no red.
- R4: A trunk lane (0, 2 or 3) stays green for HWY_GREEN_S seconds. A minor lane (1 or 4) stays green for SIDE_GREEN_S seconds. One second is TICKS_PER_SEC clock cycles.
- R5: Every green interval is followed directly by YEL_S seconds of yellow on the same lane.
- R6: In the cycle a yellow interval ends, that lane turns red and the next served lane turns green. The next lane is the current lane plus one, wrapping from 4 to 0. A skipped minor lane adds one more step.
- R7: When lane 0's yellow ends, lane 1 is served if side1_busy was 1 on that clock edge. If it was 0, lane 2 turns green. The value of side1_busy at any other time has no effect.
- R8: When lane 3's yellow ends, lane 4 is served if side4_busy was 1 on that clock edge. If it was 0, lane 0 turns green. The value of side4_busy at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, fixed frequency of TICKS_PER_SEC cycles per second |
| rst_n | input | 1 | Synchronous reset, active low |
| side1_busy | input | 1 | Presence detector of minor lane 1 (1 = vehicle waiting) |
| side4_busy | input | 1 | Presence detector of minor lane 4 (1 = vehicle waiting) |
| lamp_red | output | 5 | Red lamps, bit i = lane i |
| lamp_grn | output | 5 | Green lamps, bit i = lane i |
| lamp_yel | output | 5 | Yellow lamps, bit i = lane i |

## Verification
The sequence is walked cycle by cycle, with all three lamp vectors compared in every cycle, under four detector patterns:
- **Both detectors set.** This exposes the full five-lane order and both green lengths.
- **Both detectors clear.** This proves that lane 3 hands over to lane 0 and lane 0 hands over to lane 2.
- **Only lane 1's detector set.** This separates the two skip paths from each other.
- **Detector pulses against the expiry edge.** Here the lane 4 detector is held high and then dropped just before lane 3's yellow ends, and the lane 1 detector is raised only in the last yellow cycle of lane 0. This shows that only the value at the expiry edge counts.

A reset in the middle of a trunk green confirms that the sequence restarts at lane 2 with a full, unshortened interval.

// File: rtl/lsc_pkg.sv
// Package lsc_pkg
// Shared constants, the phase type and the lane-advance rule of the junction
// sequencer. Assumes five lanes, with lanes 1 and 4 as detector-gated minor lanes.
package lsc_pkg;

    localparam int NLANES = 5;
    localparam int LANE_W = $clog2(NLANES);
    localparam logic [LANE_W-1:0] START_LANE = LANE_W'(2);
    localparam logic [NLANES-1:0] SIDE_MASK  = 5'b10010;

    typedef enum logic {
        PH_GREEN  = 1'b0,
        PH_YELLOW = 1'b1
    } phase_e;

    // One step up the lane index, wrapping at the last lane.
    function automatic logic [LANE_W-1:0] lsc_step(input logic [LANE_W-1:0] cur);
        return (cur == LANE_W'(NLANES - 1)) ? '0 : cur + 1'b1;
    endfunction

    // Lane served after cur: skip a minor lane whose detector is clear.
    function automatic logic [LANE_W-1:0] lsc_next(input logic [LANE_W-1:0] cur,
                                                  input logic [NLANES-1:0] busy);
        logic [LANE_W-1:0] c;
        c = lsc_step(cur);
        if (SIDE_MASK[c] && !busy[c])
            c = lsc_step(c);
        return c;
    endfunction

endpackage

// File: rtl/lsc_sec_tick.sv
// Module lsc_sec_tick
// Divides the clock into a one-cycle pulse every TICKS_PER_SEC cycles.
// Assumes TICKS_PER_SEC >= 2. A synchronous reset restarts the count, so the
// first pulse lands on the TICKS_PER_SEC-th edge after reset is released.
module lsc_sec_tick #(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic sec_tick
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt;

    assign sec_tick = (cnt == CNT_LAST);

    // Purpose: free-running modulo-TICKS_PER_SEC counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (sec_tick) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lsc_phase_seq.sv
// Module lsc_phase_seq
// Holds the served lane, its phase (green or yellow) and the seconds left in
// that phase. Assumes one sec_tick pulse per second. A phase loaded with N
// seconds ends on the N-th pulse after it is entered.
module lsc_phase_seq
    import lsc_pkg::*;
#(
    parameter int HWY_GREEN_S  = 60,
    parameter int SIDE_GREEN_S = 30,
    parameter int YEL_S        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick,
    input  logic [NLANES-1:0]    busy,
    output logic [LANE_W-1:0]    lane,
    output phase_e               phase
);
    localparam int MAX_S = (HWY_GREEN_S > SIDE_GREEN_S)
                         ? ((HWY_GREEN_S > YEL_S) ? HWY_GREEN_S : YEL_S)
                         : ((SIDE_GREEN_S > YEL_S) ? SIDE_GREEN_S : YEL_S);
    localparam int SEC_W = $clog2(MAX_S + 1);
    localparam logic [SEC_W-1:0] HWY_LOAD  = SEC_W'(HWY_GREEN_S - 1);
    localparam logic [SEC_W-1:0] SIDE_LOAD = SEC_W'(SIDE_GREEN_S - 1);
    localparam logic [SEC_W-1:0] YEL_LOAD  = SEC_W'(YEL_S - 1);

    logic [SEC_W-1:0]  secs_left;
    logic [LANE_W-1:0] lane_nxt;
    logic              expire;

    assign expire   = sec_tick && (secs_left == '0);
    assign lane_nxt = lsc_next(lane, busy);

    // Purpose: count down the current phase and advance lane/phase on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane      <= START_LANE;
            phase     <= PH_GREEN;
            secs_left <= SIDE_MASK[START_LANE] ? SIDE_LOAD : HWY_LOAD;
        end else if (expire) begin
            if (phase == PH_GREEN) begin
                phase     <= PH_YELLOW;
                secs_left <= YEL_LOAD;
            end else begin
                lane      <= lane_nxt;
                phase     <= PH_GREEN;
                secs_left <= SIDE_MASK[lane_nxt] ? SIDE_LOAD : HWY_LOAD;
            end
        end else if (sec_tick) begin
            secs_left <= secs_left - 1'b1;
        end
    end
endmodule

// File: rtl/lsc_lamp_drive.sv
// Module lsc_lamp_drive
// Decodes the served lane and phase into the three lamp vectors, one slice per
// lane. Assumes lane is always below NLANES.
module lsc_lamp_drive
    import lsc_pkg::*;
(
    input  logic [LANE_W-1:0] lane,
    input  phase_e            phase,
    output logic [NLANES-1:0] red,
    output logic [NLANES-1:0] grn,
    output logic [NLANES-1:0] yel
);
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic sel;
        // Purpose: light exactly one lamp of lane i.
        always_comb begin
            sel    = (lane == LANE_W'(i));
            grn[i] = sel && (phase == PH_GREEN);
            yel[i] = sel && (phase == PH_YELLOW);
            red[i] = !sel;
        end
    end
endmodule

// File: rtl/lane_signal_ctrl.sv
// Module lane_signal_ctrl
// Top of the five-lane junction sequencer: prescaler, phase sequencer and
// lamp decoder. Assumes a fixed clock of TICKS_PER_SEC cycles per second and
// detector inputs already synchronous to clk.
module lane_signal_ctrl
    import lsc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000,
    parameter int HWY_GREEN_S   = 60,
    parameter int SIDE_GREEN_S  = 30,
    parameter int YEL_S         = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       side1_busy,
    input  logic       side4_busy,
    output logic [4:0] lamp_red,
    output logic [4:0] lamp_grn,
    output logic [4:0] lamp_yel
);
    logic              sec_tick;
    logic [NLANES-1:0] busy;
    logic [LANE_W-1:0] lane;
    phase_e            phase;

    assign busy = {side4_busy, 1'b0, 1'b0, side1_busy, 1'b0};

    lsc_sec_tick #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick)
    );

    lsc_phase_seq #(
        .HWY_GREEN_S  (HWY_GREEN_S),
        .SIDE_GREEN_S (SIDE_GREEN_S),
        .YEL_S        (YEL_S)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .busy     (busy),
        .lane     (lane),
        .phase    (phase)
    );

    lsc_lamp_drive u_lamps (
        .lane  (lane),
        .phase (phase),
        .red   (lamp_red),
        .grn   (lamp_grn),
        .yel   (lamp_yel)
    );
endmodule

// File: rtl/lsc_checker.sv
// Module lsc_checker
// Port-level properties of lane_signal_ctrl, bound into every instance. It
// measures phase lengths with its own cycle counter, so the timing window does
// not depend on $past depth.
module lsc_checker #(
    parameter int TICKS_PER_SEC = 100_000_000,
    parameter int HWY_GREEN_S   = 60,
    parameter int SIDE_GREEN_S  = 30,
    parameter int YEL_S         = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       side1_busy,
    input logic       side4_busy,
    input logic [4:0] lamp_red,
    input logic [4:0] lamp_grn,
    input logic [4:0] lamp_yel
);
    localparam logic [63:0] HWY_CYC  = 64'(HWY_GREEN_S)  * 64'(TICKS_PER_SEC);
    localparam logic [63:0] SIDE_CYC = 64'(SIDE_GREEN_S) * 64'(TICKS_PER_SEC);
    localparam logic [63:0] YEL_CYC  = 64'(YEL_S)        * 64'(TICKS_PER_SEC);
    localparam logic [4:0]  MINOR    = 5'b10010;

    logic [9:0]  prev_lamps;
    logic [63:0] hold;

    // Purpose: count the cycles the current lamp pattern has been shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= '0;
            prev_lamps <= {lamp_grn, lamp_yel};
        end else begin
            hold       <= ({lamp_grn, lamp_yel} != prev_lamps) ? 64'd1 : hold + 64'd1;
            prev_lamps <= {lamp_grn, lamp_yel};
        end
    end

    a_r1_start_lane2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lamp_grn == 5'b00100 && lamp_yel == 5'b0));

    a_r2_single_lit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lamp_grn | lamp_yel) == 1) && ((lamp_grn & lamp_yel) == 5'b0));

    a_r3_red_rest: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_red == ~(lamp_grn | lamp_yel));

    a_r4_green_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lamp_yel) |->
            hold == ((|($past(lamp_grn) & MINOR)) ? SIDE_CYC : HWY_CYC));

    a_r5_yel_same_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lamp_yel) |-> lamp_yel == $past(lamp_grn));

    a_r5_yel_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|lamp_yel) |-> hold == YEL_CYC);

    a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|lamp_yel) |->
            (lamp_grn == {$past(lamp_yel[3:0]), $past(lamp_yel[4])}) ||
            (lamp_grn == {$past(lamp_yel[2:0]), $past(lamp_yel[4:3])}));

    a_r7_side1_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(|lamp_yel) && $past(lamp_yel[0])) |-> lamp_grn[1] == $past(side1_busy));

    a_r8_side4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(|lamp_yel) && $past(lamp_yel[3])) |-> lamp_grn[4] == $past(side4_busy));
endmodule

bind lane_signal_ctrl lsc_checker #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .HWY_GREEN_S   (HWY_GREEN_S),
    .SIDE_GREEN_S  (SIDE_GREEN_S),
    .YEL_S         (YEL_S)
) u_lsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .side1_busy (side1_busy),
    .side4_busy (side4_busy),
    .lamp_red   (lamp_red),
    .lamp_grn   (lamp_grn),
    .lamp_yel   (lamp_yel)
);

// File: tb/lane_signal_ctrl_test.sv
// Directed bench for lane_signal_ctrl. Each scenario task walks the lamp
// sequence and compares all three lamp vectors on every falling edge.
module lane_signal_ctrl_test;
    localparam int T    = 4;
    localparam int HWY  = 60;
    localparam int SIDE = 30;
    localparam int YEL  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       side1_busy = 1'b0;
    logic       side4_busy = 1'b0;
    logic [4:0] lamp_red, lamp_grn, lamp_yel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    lane_signal_ctrl #(
        .TICKS_PER_SEC (T),
        .HWY_GREEN_S   (HWY),
        .SIDE_GREEN_S  (SIDE),
        .YEL_S         (YEL)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .side1_busy (side1_busy),
        .side4_busy (side4_busy),
        .lamp_red   (lamp_red),
        .lamp_grn   (lamp_grn),
        .lamp_yel   (lamp_yel)
    );

    always #5 clk = ~clk;

    // Hold reset for three edges, release it at a falling edge, and stay there.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Expect lane shown in the given phase for ncyc falling edges; one check.
    task automatic hold_phase(input int lane, input bit yel, input int ncyc, input string tag);
        logic [4:0] eg, ey, er;
        int bad;
        bad = 0;
        eg  = yel ? 5'b0 : 5'(1 << lane);
        ey  = yel ? 5'(1 << lane) : 5'b0;
        er  = ~5'(1 << lane);
        for (int c = 0; c < ncyc; c++) begin
            if ((lamp_grn !== eg || lamp_yel !== ey || lamp_red !== er) && bad == 0) begin
                $display("FAIL %s lane%0d yel=%0d cyc%0d: got r=%b g=%b y=%b exp r=%b g=%b y=%b",
                         tag, lane, yel, c, lamp_red, lamp_grn, lamp_yel, er, eg, ey);
                bad = 1;
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) failures++;
    endtask

    // A full green-then-yellow service of one lane.
    task automatic serve(input int lane, input string tag);
        int gs;
        gs = (lane == 1 || lane == 4) ? SIDE : HWY;
        hold_phase(lane, 1'b0, gs * T, tag);
        hold_phase(lane, 1'b1, YEL * T, tag);
    endtask

    // R1: the reset state, then a full 60 s green on lane 2.
    task automatic t_reset_state();
        side1_busy = 1'b1; side4_busy = 1'b1;
        do_reset();
        hold_phase(2, 1'b0, 1, "R1 reset state");
        hold_phase(2, 1'b0, HWY * T - 1, "R1 first green length");
        hold_phase(2, 1'b1, YEL * T, "R5 yellow after lane2");
    endtask

    // R2 R3 R4 R5 R6: both detectors set, so the full order 2,3,4,0,1 and the wrap.
    task automatic t_all_busy();
        side1_busy = 1'b1; side4_busy = 1'b1;
        do_reset();
        serve(2, "R4 R6 lane2");
        serve(3, "R4 R6 lane3");
        serve(4, "R4 R8 lane4 served");
        serve(0, "R4 R6 lane0");
        serve(1, "R4 R7 lane1 served");
        hold_phase(2, 1'b0, 1, "R6 wrap to lane2");
    endtask

    // R7 R8: both detectors clear, so 3 goes to 0 and 0 goes to 2.
    task automatic t_none_busy();
        side1_busy = 1'b0; side4_busy = 1'b0;
        do_reset();
        serve(2, "R2 lane2");
        serve(3, "R8 lane3 before skip");
        serve(0, "R8 lane4 skipped");
        hold_phase(2, 1'b0, 1, "R7 lane1 skipped");
    endtask

    // R7 R8: only lane 1's detector set.
    task automatic t_mixed();
        side1_busy = 1'b1; side4_busy = 1'b0;
        do_reset();
        serve(2, "R3 lane2");
        serve(3, "R3 lane3");
        serve(0, "R8 lane4 skipped mixed");
        serve(1, "R7 lane1 served mixed");
        hold_phase(2, 1'b0, 1, "R6 back to lane2 mixed");
    endtask

    // R7 R8: only the detector value on the expiry edge counts.
    task automatic t_sample_edge();
        side1_busy = 1'b0; side4_busy = 1'b1;
        do_reset();
        serve(2, "R6 lane2 edge");
        hold_phase(3, 1'b0, HWY * T, "R4 lane3 edge");
        hold_phase(3, 1'b1, YEL * T - 1, "R5 lane3 yellow edge");
        side4_busy = 1'b0;
        hold_phase(3, 1'b1, 1, "R5 lane3 yellow last cycle");
        hold_phase(0, 1'b0, HWY * T, "R8 detector dropped before expiry");
        hold_phase(0, 1'b1, YEL * T - 1, "R5 lane0 yellow edge");
        side1_busy = 1'b1;
        hold_phase(0, 1'b1, 1, "R5 lane0 yellow last cycle");
        side1_busy = 1'b0;
        hold_phase(1, 1'b0, SIDE * T, "R7 detector raised at expiry");
        hold_phase(1, 1'b1, YEL * T, "R5 lane1 yellow edge");
        hold_phase(2, 1'b0, 1, "R6 lane2 after lane1");
    endtask

    // R1: reset in the middle of lane 3's green restarts at lane 2 with a full green.
    task automatic t_mid_reset();
        side1_busy = 1'b1; side4_busy = 1'b1;
        do_reset();
        serve(2, "R6 lane2 pre-reset");
        hold_phase(3, 1'b0, 10 * T + 1, "R4 lane3 pre-reset");
        do_reset();
        hold_phase(2, 1'b0, HWY * T, "R1 full green after mid reset");
        hold_phase(2, 1'b1, 1, "R1 yellow after mid reset");
    endtask

    initial begin
        t_reset_state();
        t_all_busy();
        t_none_busy();
        t_mixed();
        t_sample_edge();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, got timeout exp finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule